// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Controller

This block watches a set of asynchronous input lines and turns a selected edge on any of them into a latched event. Every line passes through a synchronizer and an edge detector. A channel can be switched on or off individually, and a per-channel polarity bit selects whether a rising or a falling transition counts. A qualifying edge on an enabled channel sets a sticky pending bit. Software clears a pending bit by writing a one to it.

The enabled pending bits serve two consumers. Each channel has a small assignment field that steers it onto one of several interrupt lines, so the block can act as a bank of maskable edge-triggered interrupts. The OR of all enabled pending bits drives a wake-up request. That request is decoded from register state with no clocked stage after it, so it stays valid while the main clock is stopped and can bring a power-mode sequencer out of a low-power state.

Configuration uses a simple single-cycle register port. A write is taken on the clock edge at which `cfg_we` is high. There is no back-pressure: every write is accepted in its own cycle. Read data is a combinational decode of `cfg_addr`. Address map, 16 bits per word: 0 channel enable, 1 edge polarity, 2 pending, 3 and 4 interrupt assignment. Other addresses read as zero and ignore writes.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset the enable, polarity, pending and assignment registers are all zero, and `irq_o` and `wake_o` are low.
- R2: With polarity bit c at 0 (the reset value), a rising transition on `line_i[c]` of an enabled channel sets pending bit c. A falling transition does not.
- R3: With polarity bit c at 1, a falling transition on `line_i[c]` of an enabled channel sets pending bit c. A rising transition does not.
- R4: An edge on a channel whose enable bit is 0 leaves its pending bit unchanged.
- R5: Writing address 2 clears each pending bit whose data bit is 1 and leaves bits written with 0 untouched. A qualifying edge in the same cycle as the clearing write keeps the bit set.
- R6: A write to the polarity register never sets a pending bit by itself, even when the line sits at a level that now matches the new polarity. The detector is re-primed for every channel whose polarity changes.
- R7: `irq_o[k]` is high exactly when some channel with enable and pending both 1 has its 2-bit assignment field equal to k. The field of channel c lies in bits [2*(c%8)+1 : 2*(c%8)] of word 3 + c/8.
- R8: `wake_o` is the OR over channels of enable AND pending, decoded from register state with no clocked stage after it. Clearing an enable bit removes the channel's contribution without clearing its pending bit.
- R9: A pending bit is set on the third rising clock edge after the line changes: two synchronizer stages, then the edge-detection register.
- R10: The enable, polarity and assignment registers read back the value last written. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 16 | Asynchronous input lines, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for writes and reads |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| irq_o | output | 4 | Grouped interrupt lines |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions assume that reset is low from time zero and that `cfg_addr` and `cfg_wdata` hold defined values whenever `cfg_we` is high. They also assume that line changes reach the detector only through the synchronizer, so each detection is a clean one-cycle event. The stimulus changes lines and register inputs only on falling clock edges. It holds each line level for at least four cycles so that every transition is seen exactly once. In the same-cycle clear case it places the write strobe on the exact cycle in which the edge is detected.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd2;
  localparam int unsigned RT_BASE = 3;
endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[c]};
    end
    assign dout[c] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ewc_edge.sv
module ewc_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] hold,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev_q;

  // the previous level always follows the synchronized line, so a re-prime
  // only has to suppress detection in the cycle of the polarity write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar c = 0; c < N; c++) begin : g_det
    logic up, down;
    assign up     = lvl[c] & ~prev_q[c];
    assign down   = ~lvl[c] & prev_q[c];
    assign hit[c] = ~hold[c] & (pol[c] ? down : up);
  end
endmodule

// File: rtl/ewc_regs.sv
module ewc_regs
  import ewc_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned IRQS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [N-1:0]      cfg_wdata,
  output logic [N-1:0]      cfg_rdata,
  input  logic [N-1:0]      hit,
  output logic [N-1:0]      hold,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      pend_q,
  output logic [N*((IRQS > 1) ? $clog2(IRQS) : 1)-1:0] route_q
);
  localparam int unsigned RW   = (IRQS > 1) ? $clog2(IRQS) : 1;
  localparam int unsigned CPW  = N / RW;
  localparam int unsigned NRTW = (N + CPW - 1) / CPW;

  logic [N-1:0] clr;
  logic [N-1:0] rt_word [NRTW];

  assign clr  = (cfg_we && cfg_addr == A_PEND) ? cfg_wdata : '0;
  assign hold = (cfg_we && cfg_addr == A_POL) ? (cfg_wdata ^ pol_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      if (cfg_we && cfg_addr == A_EN)  en_q  <= cfg_wdata;
      if (cfg_we && cfg_addr == A_POL) pol_q <= cfg_wdata;
      pend_q <= (pend_q & ~clr) | (hit & en_q);
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_rt
    localparam int unsigned W = c / CPW;
    localparam int unsigned S = c % CPW;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[c*RW +: RW] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(RT_BASE + W))
        route_q[c*RW +: RW] <= cfg_wdata[S*RW +: RW];
    end
  end

  for (genvar w = 0; w < NRTW; w++) begin : g_rtw
    always_comb begin
      rt_word[w] = '0;
      for (int s = 0; s < CPW; s++)
        if (w * CPW + s < N)
          rt_word[w][s*RW +: RW] = route_q[(w*CPW+s)*RW +: RW];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      A_EN:    cfg_rdata = en_q;
      A_POL:   cfg_rdata = pol_q;
      A_PEND:  cfg_rdata = pend_q;
      default: begin
        for (int w = 0; w < NRTW; w++)
          if (cfg_addr == ADDR_W'(RT_BASE + w)) cfg_rdata = rt_word[w];
      end
    endcase
  end
endmodule

// File: rtl/ewc_route.sv
module ewc_route #(
  parameter int unsigned N    = 16,
  parameter int unsigned IRQS = 4
) (
  input  logic [N-1:0]    en,
  input  logic [N-1:0]    pend,
  input  logic [N*((IRQS > 1) ? $clog2(IRQS) : 1)-1:0] route,
  output logic [IRQS-1:0] irq,
  output logic            wake
);
  localparam int unsigned RW = (IRQS > 1) ? $clog2(IRQS) : 1;

  logic [N-1:0] live;
  assign live = en & pend;

  for (genvar k = 0; k < IRQS; k++) begin : g_irq
    always_comb begin
      irq[k] = 1'b0;
      for (int c = 0; c < N; c++)
        if (live[c] && route[c*RW +: RW] == RW'(k)) irq[k] = 1'b1;
    end
  end

  assign wake = |live;
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
  import ewc_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned IRQS   = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      line_i,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [N-1:0]      cfg_wdata,
  output logic [N-1:0]      cfg_rdata,
  output logic [IRQS-1:0]   irq_o,
  output logic              wake_o
);
  localparam int unsigned RW = (IRQS > 1) ? $clog2(IRQS) : 1;

  logic [N-1:0]    lvl, hit, hold, en_q, pol_q, pend_q;
  logic [N*RW-1:0] route_q;

  ewc_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_i), .dout(lvl));

  ewc_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol_q), .hold(hold), .hit(hit));

  ewc_regs #(.N(N), .IRQS(IRQS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hit(hit), .hold(hold),
    .en_q(en_q), .pol_q(pol_q), .pend_q(pend_q), .route_q(route_q));

  ewc_route #(.N(N), .IRQS(IRQS)) u_route (
    .en(en_q), .pend(pend_q), .route(route_q), .irq(irq_o), .wake(wake_o));
endmodule

// File: rtl/ewc_chk.sv
module ewc_chk
  import ewc_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned IRQS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [N-1:0]      cfg_wdata,
  input logic [IRQS-1:0]   irq_o,
  input logic              wake_o,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      pol_q,
  input logic [N-1:0]      pend_q
);
  logic [N-1:0] clr_mask;
  assign clr_mask = (cfg_we && cfg_addr == A_PEND) ? cfg_wdata : '0;

  // R4: a pending bit can only rise where the channel was enabled
  p_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R5: a pending bit falls only under a clearing write
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(clr_mask) & ~pend_q) == '0));

  // R6: a polarity write sets no pending bit for channels it changes
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_POL) |=>
      ((pend_q & ~$past(pend_q) & $past(cfg_wdata ^ pol_q)) == '0));

  // R7: wake and the grouped lines agree
  p_wake_vs_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == (|irq_o));

  // R8: disabling every channel drops the wake request
  p_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_EN && cfg_wdata == '0) |=> !wake_o);
endmodule

bind edge_wake_ctrl ewc_chk #(.N(N), .IRQS(IRQS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .irq_o(irq_o), .wake_o(wake_o),
  .en_q(en_q), .pol_q(pol_q), .pend_q(pend_q));

// File: tb/test_edge_wake_ctrl.sv
`timescale 1ns/1ps
module test_edge_wake_ctrl;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] line_i = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd2;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  irq_o;
  logic        wake_o;

  always #2.5 clk = ~clk;

  edge_wake_ctrl i_edge_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o), .wake_o(wake_o));

  typedef struct {
    string       req;
    logic [15:0] pend;
    logic [3:0]  irq;
    logic        wake;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_en = '0, m_pol = '0, m_pend = '0;
  int m_route [16];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] m_irq();
    logic [3:0] r = '0;
    for (int c = 0; c < N; c++)
      if (m_en[c] && m_pend[c]) r[m_route[c]] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] m_rtword(int w);
    logic [15:0] r = '0;
    for (int s = 0; s < 8; s++) r[2*s +: 2] = 2'(m_route[w*8+s]);
    return r;
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(it.req, "pending", cfg_rdata, it.pend);
        chk(it.req, "irq", {12'd0, irq_o}, {12'd0, it.irq});
        chk(it.req, "wake", {15'd0, wake_o}, {15'd0, it.wake});
      end
    end
  end

  task automatic expect_state(string req);
    exp_t it;
    it.req = req; it.pend = m_pend; it.irq = m_irq(); it.wake = |(m_en & m_pend);
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 3'd2;
    case (a)
      3'd0: m_en = d;
      3'd1: m_pol = d;
      3'd2: m_pend = m_pend & ~d;
      3'd3, 3'd4: for (int s = 0; s < 8; s++) m_route[(a-3)*8+s] = int'(d[2*s +: 2]);
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, "readback", cfg_rdata, exp);
    cfg_addr = 3'd2;
  endtask

  task automatic drive_lines(logic [15:0] v);
    logic [15:0] rise, fall;
    @(negedge clk);
    rise = v & ~line_i; fall = line_i & ~v;
    line_i = v;
    repeat (4) @(negedge clk);
    m_pend = m_pend | (m_en & ((~m_pol & rise) | (m_pol & fall)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < N; c++) m_route[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_state("R1");
    rd(3'd0, 16'h0000, "R1");
    rd(3'd3, 16'h0000, "R1");

    wr(3'd3, 16'hE4E4);
    wr(3'd4, 16'hE4E4);
    wr(3'd0, 16'h00FF);
    // R10 readback
    rd(3'd0, 16'h00FF, "R10");
    rd(3'd3, m_rtword(0), "R10");
    rd(3'd4, m_rtword(1), "R10");
    rd(3'd7, 16'h0000, "R10");

    // R2 rising edge sets pending and routes to irq0
    drive_lines(16'h0001);
    expect_state("R2");
    drive_lines(16'h0000);
    expect_state("R2");

    // R4 disabled channel ignored
    drive_lines(16'h0100);
    expect_state("R4");
    drive_lines(16'h0000);

    // R3 falling polarity
    wr(3'd1, 16'h0002);
    rd(3'd1, 16'h0002, "R10");
    drive_lines(16'h0002);
    expect_state("R3");
    drive_lines(16'h0000);
    expect_state("R3");

    // R5 write-one-to-clear, zeros untouched
    wr(3'd2, 16'h0001);
    expect_state("R5");
    wr(3'd2, 16'h0000);
    expect_state("R5");

    // R9 latency, channel 5
    @(negedge clk);
    line_i = 16'h0020;
    @(negedge clk);
    chk("R9", "pending early", cfg_rdata & 16'h0020, 16'h0000);
    @(negedge clk);
    chk("R9", "pending edge2", cfg_rdata & 16'h0020, 16'h0000);
    @(negedge clk);
    chk("R9", "pending edge3", cfg_rdata & 16'h0020, 16'h0020);
    m_pend[5] = 1'b1;
    repeat (2) @(negedge clk);
    expect_state("R9");

    // R5 edge in the same cycle as the clear keeps the bit
    drive_lines(16'h0028);
    drive_lines(16'h0020);
    @(negedge clk);
    line_i = 16'h0028;
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 16'h0008;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    expect_state("R5");

    // R6 polarity change while line is high
    wr(3'd2, 16'hFFFF);
    expect_state("R6");
    drive_lines(16'h002C);
    wr(3'd2, 16'h0004);
    wr(3'd1, 16'h0006);
    repeat (3) @(negedge clk);
    expect_state("R6");
    drive_lines(16'h0028);
    expect_state("R6");

    // R7 reassign channel 2 to irq3
    wr(3'd3, 16'hE4F4);
    expect_state("R7");
    rd(3'd3, 16'hE4F4, "R7");

    // R8 enable removal keeps pending
    wr(3'd0, 16'h0000);
    expect_state("R8");
    wr(3'd0, 16'h00FF);
    expect_state("R8");

    finish_run();
  end
endmodule